// File: doc/BRIEF.md
# In-Band Request Issuer with Fence Ordering

This block sits on the graphics-card side of a split-transaction port and turns a stream of queued memory requests into request cycles on the shared 32-bit address/data lines. Requests enter a small local holding queue. When the head of that queue may legally go out, the block raises its bus request. It waits until the host grants the bus with status code 3'b111. It then asserts a pipe strobe, not a normal transaction start, and drives one request per cycle. Each request carries the command on the byte-enable lines, the 8-byte-aligned address on AD[31:3] and a 3-bit length code on AD[2:0]. A request whose address does not fit in 32 bits takes two cycles. The first cycle carries a dual-cycle marker command with the low address word, and the second carries the high word with the real command.

Reads and writes are weakly ordered, and the block tracks how many issued requests still await completion. It never exceeds a configured ceiling. A fence command takes no slot. After a fence goes out, every later request waits in the holding queue until all earlier requests have completed. A flush takes a slot like a read, and its address and length are not sent. Data phases, sideband issue and the electrical turnaround are handled elsewhere.

Top module: `inband_req_issuer`

## Requirements
- R1: The bus request output is high only while the pipe strobe is low and the queue head may be issued. The pipe strobe rises only in the cycle after a clock edge that saw grant high together with status 3'b111. A grant with any other status starts nothing.
- R2: During a single-cycle request beat, cbe_o carries the command, ad_o[31:3] carries address bits 31:3 and ad_o[2:0] carries the length code. Address bits 2:0 of the input are discarded.
- R3: A read, long read or write whose address bits 63:32 are not all zero goes out in two consecutive beats. The first beat carries cbe_o = 4'b1110 with address bits 31:3 and the length code. The second beat carries address bits 63:32 on ad_o and the real command on cbe_o.
- R4: The command codes are read 4'b0000, long read 4'b0001, write 4'b0100, flush 4'b1010 and fence 4'b1100. A flush or fence beat drives ad_o = 0 and never uses two beats.
- R5: The pipe strobe stays high through back-to-back beats while issuable requests remain queued, and it falls in the cycle after the last beat.
- R6: Every request except a fence takes an outstanding slot, and each cpl_i pulse frees one slot. When MAX_OUT slots are taken, no request that needs a slot is issued and the bus request stays low.
- R7: After a fence is issued while requests are outstanding, no later request is issued and the bus request stays low until the outstanding count reaches zero.
- R8: While the pipe strobe is low, ad_o and cbe_o are zero.
- R9: In reset, bus request and pipe strobe are low and in_ready is high.
- R10: The holding queue keeps DEPTH entries in arrival order. When it is full, in_ready is low and an offered request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A new request is offered |
| in_ready | output | 1 | Holding queue can accept a request |
| in_cmd | input | 4 | Command code of the offered request |
| in_addr | input | 64 | Byte address of the offered request |
| in_len | input | 3 | Length code of the offered request |
| gnt_i | input | 1 | Bus grant from the host (active high) |
| st_i | input | 3 | Bus status qualifying the grant |
| cpl_i | input | 1 | One earlier request has completed |
| req_o | output | 1 | Bus request to the host (active high) |
| pipe_o | output | 1 | Request-beat strobe (active high) |
| cbe_o | output | 4 | Command on the byte-enable lines |
| ad_o | output | 32 | Address word with the length code in bits 2:0 |

## Verification
The bench builds the block with DEPTH = 4 and MAX_OUT = 3, so a small number of pushes is enough to fill the queue past the outstanding ceiling. Three reads then exhaust the slots and leave a fourth request stalled. With the queue one entry deeper than the ceiling, the full-queue drop case and the slot stall can be combined in one sequence. The small ceiling also lets a fence be issued behind an unfinished read with only one completion pulse needed to release it.

// File: rtl/inband_req_pkg.sv
package inband_req_pkg;
  localparam int ADDR_W = 64;
  localparam int LEN_W  = 3;
  localparam int CMD_W  = 4;
  localparam int AD_W   = 32;

  localparam logic [CMD_W-1:0] CMD_RD      = 4'b0000;
  localparam logic [CMD_W-1:0] CMD_RD_LONG = 4'b0001;
  localparam logic [CMD_W-1:0] CMD_WR      = 4'b0100;
  localparam logic [CMD_W-1:0] CMD_FLUSH   = 4'b1010;
  localparam logic [CMD_W-1:0] CMD_FENCE   = 4'b1100;
  localparam logic [CMD_W-1:0] CMD_DUAL    = 4'b1110;

  localparam logic [2:0] ST_REQ_OK = 3'b111;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
  } req_t;
endpackage

// File: rtl/inband_req_fifo.sv
module inband_req_fifo
  import inband_req_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic push_i,
  input  req_t push_data_i,
  input  logic pop_i,
  output req_t head_o,
  output logic empty_o,
  output logic full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  req_t             mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_i) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (pop_i)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    if (push_i && !pop_i) cnt_d = cnt_q + 1'b1;
    else if (!push_i && pop_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem_q[wr_q] <= push_data_i;
  end

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)) else $error("fifo count over depth"); // R10
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_ni)
    pop_i |-> !empty_o) else $error("pop from empty queue"); // R10
endmodule

// File: rtl/inband_req_encode.sv
module inband_req_encode
  import inband_req_pkg::*;
(
  input  req_t             req_i,
  output logic [AD_W-1:0]  lo_ad_o,
  output logic [CMD_W-1:0] lo_cbe_o,
  output logic [AD_W-1:0]  hi_ad_o,
  output logic [CMD_W-1:0] hi_cbe_o,
  output logic             dual_o,
  output logic             slot_o,
  output logic             fence_o
);
  logic no_addr;

  always_comb begin
    no_addr  = (req_i.cmd == CMD_FLUSH) || (req_i.cmd == CMD_FENCE);
    dual_o   = !no_addr && (|req_i.addr[ADDR_W-1:AD_W]);
    lo_ad_o  = no_addr ? '0 : {req_i.addr[AD_W-1:LEN_W], req_i.len};
    lo_cbe_o = dual_o ? CMD_DUAL : req_i.cmd;
    hi_ad_o  = req_i.addr[ADDR_W-1:AD_W];
    hi_cbe_o = req_i.cmd;
    fence_o  = (req_i.cmd == CMD_FENCE);
    slot_o   = !fence_o;
  end
endmodule

// File: rtl/inband_req_order.sv
module inband_req_order #(
  parameter int MAX_OUT = 4
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic pop_i,
  input  logic pop_slot_i,
  input  logic pop_fence_i,
  input  logic cpl_i,
  output logic room_o,
  output logic hold_o
);
  localparam int OCNT_W = $clog2(MAX_OUT + 1);

  logic [OCNT_W-1:0] cnt_q, cnt_d;
  logic              hold_q, hold_d;
  logic              inc, dec;

  always_comb begin
    inc   = pop_i && pop_slot_i;
    dec   = cpl_i && (cnt_q != '0);
    cnt_d = cnt_q;
    if (inc && !dec) cnt_d = cnt_q + 1'b1;
    else if (!inc && dec) cnt_d = cnt_q - 1'b1;
    if (pop_i && pop_fence_i) hold_d = (cnt_d != '0);
    else hold_d = hold_q && (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  assign room_o = (cnt_q < OCNT_W'(MAX_OUT));
  assign hold_o = hold_q;

  AST_OUT_LIMIT: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= OCNT_W'(MAX_OUT)) else $error("outstanding over limit"); // R6
  AST_HOLD_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_ni)
    hold_q |-> (cnt_q != '0)) else $error("fence hold with nothing outstanding"); // R7
endmodule

// File: rtl/inband_req_issuer.sv
module inband_req_issuer
  import inband_req_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int MAX_OUT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CMD_W-1:0]  in_cmd,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LEN_W-1:0]  in_len,
  input  logic              gnt_i,
  input  logic [2:0]        st_i,
  input  logic              cpl_i,
  output logic              req_o,
  output logic              pipe_o,
  output logic [CMD_W-1:0]  cbe_o,
  output logic [AD_W-1:0]   ad_o
);
  logic rst_meta_q, rst_sync_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_sync_n = rst_sync_q;

  req_t             in_req, head;
  logic             empty, full, push, pop;
  logic [AD_W-1:0]  lo_ad, hi_ad;
  logic [CMD_W-1:0] lo_cbe, hi_cbe;
  logic             dual, slot, fence, room, hold;
  logic             can_issue, start;

  logic             pipe_q, pipe_d, hi_pend_q, hi_pend_d;
  logic [AD_W-1:0]  ad_q, ad_d, hi_ad_q, hi_ad_d;
  logic [CMD_W-1:0] cbe_q, cbe_d, hi_cbe_q, hi_cbe_d;

  assign in_req = '{cmd: in_cmd, addr: in_addr, len: in_len};
  assign push   = in_valid && !full;

  inband_req_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_ni(rst_sync_n), .push_i(push), .push_data_i(in_req),
    .pop_i(pop), .head_o(head), .empty_o(empty), .full_o(full)
  );

  inband_req_encode u_enc (
    .req_i(head), .lo_ad_o(lo_ad), .lo_cbe_o(lo_cbe), .hi_ad_o(hi_ad),
    .hi_cbe_o(hi_cbe), .dual_o(dual), .slot_o(slot), .fence_o(fence)
  );

  inband_req_order #(.MAX_OUT(MAX_OUT)) u_order (
    .clk(clk), .rst_ni(rst_sync_n), .pop_i(pop), .pop_slot_i(slot),
    .pop_fence_i(fence), .cpl_i(cpl_i), .room_o(room), .hold_o(hold)
  );

  always_comb begin
    can_issue = !empty && !hold && (room || !slot);
    start     = !pipe_q && can_issue && gnt_i && (st_i == ST_REQ_OK);
    pop       = 1'b0;
    pipe_d    = 1'b0;
    ad_d      = '0;
    cbe_d     = '0;
    hi_pend_d = 1'b0;
    hi_ad_d   = hi_ad_q;
    hi_cbe_d  = hi_cbe_q;
    if (hi_pend_q) begin
      pipe_d = 1'b1;
      ad_d   = hi_ad_q;
      cbe_d  = hi_cbe_q;
    end else if (pipe_q ? can_issue : start) begin
      pop       = 1'b1;
      pipe_d    = 1'b1;
      ad_d      = lo_ad;
      cbe_d     = lo_cbe;
      hi_pend_d = dual;
      hi_ad_d   = hi_ad;
      hi_cbe_d  = hi_cbe;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pipe_q    <= 1'b0;
      hi_pend_q <= 1'b0;
      ad_q      <= '0;
      cbe_q     <= '0;
      hi_ad_q   <= '0;
      hi_cbe_q  <= '0;
    end else begin
      pipe_q    <= pipe_d;
      hi_pend_q <= hi_pend_d;
      ad_q      <= ad_d;
      cbe_q     <= cbe_d;
      hi_ad_q   <= hi_ad_d;
      hi_cbe_q  <= hi_cbe_d;
    end
  end

  assign in_ready = !full;
  assign req_o    = !pipe_q && can_issue;
  assign pipe_o   = pipe_q;
  assign ad_o     = ad_q;
  assign cbe_o    = cbe_q;

  AST_PIPE_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(pipe_q) |-> $past(gnt_i && (st_i == ST_REQ_OK))) else $error("pipe without grant"); // R1
  AST_DUAL_SECOND_BEAT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pipe_q && (cbe_q == CMD_DUAL)) |=> (pipe_q && (cbe_q != CMD_DUAL))) else $error("dual cycle broken"); // R3
  AST_FENCE_STOPS_PIPE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pipe_q && (cbe_q == CMD_FENCE) && hold) |=> !pipe_q) else $error("issue past fence"); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pipe_q |-> ((ad_q == '0) && (cbe_q == '0))) else $error("lines not quiet"); // R8
endmodule

// File: tb/sim_inband_req_issuer.sv
module sim_inband_req_issuer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [3:0]  in_cmd;
  logic [63:0] in_addr;
  logic [2:0]  in_len;
  logic        gnt_i;
  logic [2:0]  st_i;
  logic        cpl_i;
  logic        req_o, pipe_o;
  logic [3:0]  cbe_o;
  logic [31:0] ad_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  inband_req_issuer #(.DEPTH(4), .MAX_OUT(3)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cmd(in_cmd), .in_addr(in_addr), .in_len(in_len), .gnt_i(gnt_i),
    .st_i(st_i), .cpl_i(cpl_i), .req_o(req_o), .pipe_o(pipe_o),
    .cbe_o(cbe_o), .ad_o(ad_o)
  );

  // fields: cmd[139:136] addr[135:72] len[71:69] ad0[68:37] cbe0[36:33] dual[32] ad1[31:0]
  localparam logic [139:0] VEC [7] = '{
    {4'h0, 64'h0000_0000_1234_5678, 3'd3, 32'h1234_567B, 4'h0, 1'b0, 32'h0},
    {4'h4, 64'h0000_0000_8000_0010, 3'd0, 32'h8000_0010, 4'h4, 1'b0, 32'h0},
    {4'h1, 64'h0000_0000_0000_FFF8, 3'd7, 32'h0000_FFFF, 4'h1, 1'b0, 32'h0},
    {4'h0, 64'h0000_0001_0000_0040, 3'd1, 32'h0000_0041, 4'hE, 1'b1, 32'h0000_0001},
    {4'h4, 64'h0000_ABCD_2000_0007, 3'd5, 32'h2000_0005, 4'hE, 1'b1, 32'h0000_ABCD},
    {4'hA, 64'h0000_0005_DEAD_BEE8, 3'd6, 32'h0000_0000, 4'hA, 1'b0, 32'h0},
    {4'hC, 64'hFFFF_FFFF_FFFF_FFF8, 3'd2, 32'h0000_0000, 4'hC, 1'b0, 32'h0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] c, input logic [63:0] a, input logic [2:0] l);
    in_valid = 1'b1; in_cmd = c; in_addr = a; in_len = l;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic grant_once();
    gnt_i = 1'b1; st_i = 3'b111;
    @(negedge clk);
    gnt_i = 1'b0; st_i = 3'b000;
  endtask

  task automatic cpl_pulse();
    cpl_i = 1'b1;
    @(negedge clk);
    cpl_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_cmd = '0; in_addr = '0; in_len = '0;
    gnt_i = 1'b0; st_i = '0; cpl_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset req", req_o, 0);
    chk("R9 reset pipe", pipe_o, 0);
    chk("R9 reset ready", in_ready, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 idle ad", ad_o, 0);

    // table walk: one request per vector
    for (int i = 0; i < 7; i++) begin
      logic [139:0] v;
      v = VEC[i];
      push(v[139:136], v[135:72], v[71:69]);
      chk("R1 request raised", req_o, 1);
      grant_once();
      chk("R1 pipe after grant", pipe_o, 1);
      chk("R2 R4 beat0 cbe", cbe_o, v[36:33]);
      chk("R2 R4 beat0 ad", ad_o, v[68:37]);
      if (v[32]) begin
        @(negedge clk);
        chk("R3 second beat pipe", pipe_o, 1);
        chk("R3 second beat cbe", cbe_o, v[139:136]);
        chk("R3 second beat ad", ad_o, v[31:0]);
      end
      @(negedge clk);
      chk("R5 pipe released", pipe_o, 0);
      chk("R8 quiet cbe", cbe_o, 0);
      if (v[139:136] != 4'hC) cpl_pulse();
    end

    // grant with wrong status starts nothing
    push(4'h0, 64'h80, 3'd0);
    gnt_i = 1'b1; st_i = 3'b001;
    @(negedge clk);
    gnt_i = 1'b0; st_i = 3'b000;
    chk("R1 wrong status no pipe", pipe_o, 0);
    chk("R1 request held", req_o, 1);
    grant_once();
    chk("R1 late grant ad", ad_o, 32'h80);
    @(negedge clk);
    cpl_pulse();

    // back-to-back and outstanding limit
    push(4'h0, 64'h100, 3'd0);
    push(4'h0, 64'h200, 3'd0);
    push(4'h0, 64'h300, 3'd0);
    grant_once();
    chk("R5 b2b first", ad_o, 32'h100);
    @(negedge clk);
    chk("R5 b2b second pipe", pipe_o, 1);
    chk("R5 b2b second", ad_o, 32'h200);
    @(negedge clk);
    chk("R5 b2b third", ad_o, 32'h300);
    @(negedge clk);
    chk("R5 pipe falls after last", pipe_o, 0);
    push(4'h0, 64'h400, 3'd0);
    chk("R6 limit blocks request", req_o, 0);
    cpl_pulse();
    chk("R6 slot freed request", req_o, 1);
    grant_once();
    chk("R6 stalled request issued", ad_o, 32'h400);
    @(negedge clk);
    repeat (3) cpl_pulse();

    // fence holds later requests
    push(4'h0, 64'h500, 3'd0);
    push(4'hC, 64'h0, 3'd0);
    push(4'h0, 64'h600, 3'd0);
    grant_once();
    chk("R7 pre-fence read", ad_o, 32'h500);
    @(negedge clk);
    chk("R7 fence beat cbe", cbe_o, 4'hC);
    @(negedge clk);
    chk("R7 pipe stops after fence", pipe_o, 0);
    chk("R7 request held by fence", req_o, 0);
    @(negedge clk);
    chk("R7 still held", req_o, 0);
    cpl_pulse();
    chk("R7 released after completion", req_o, 1);
    grant_once();
    chk("R7 post-fence read", ad_o, 32'h600);
    @(negedge clk);
    cpl_pulse();

    // full queue drops extra request, order preserved
    push(4'h0, 64'h1000, 3'd0);
    push(4'h0, 64'h2000, 3'd0);
    push(4'h0, 64'h3000, 3'd0);
    chk("R10 ready with room", in_ready, 1);
    push(4'h0, 64'h4000, 3'd0);
    chk("R10 full not ready", in_ready, 0);
    push(4'h0, 64'hBAD0, 3'd0);
    grant_once();
    chk("R10 order 1", ad_o, 32'h1000);
    @(negedge clk);
    chk("R10 order 2", ad_o, 32'h2000);
    @(negedge clk);
    chk("R10 order 3", ad_o, 32'h3000);
    @(negedge clk);
    cpl_pulse();
    grant_once();
    chk("R10 order 4", ad_o, 32'h4000);
    @(negedge clk);
    cpl_pulse();
    chk("R10 dropped entry absent", req_o, 0);
    repeat (2) cpl_pulse();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule